// File: doc/BRIEF.md
# I2S Master Serial Audio Transmitter

This block is the clock master and the transmitter for one stereo I2S link. From one fast input clock it derives three outputs: a master clock for the codec, a bit clock and a word-select (left/right) clock. Each left/right sample pair is shifted out on a single serial data line. A frame has 64 bit clocks, so each channel gets a 32-bit slot. A 16-bit sample fills the upper half of its slot and the lower half is sent as zeros. With the default ratios, a 49.152 MHz input gives a 12.288 MHz master clock, a 3.072 MHz bit clock and a 48 kHz frame rate.

Sample pairs arrive on a valid/ready stream, which stands in for a DMA feed. The block holds one pair ahead of the frame being sent. Three one-cycle command inputs control it: software reset, clock enable and transmit enable. The `tx_active` status output confirms that transmission has started, and it rises only at a frame boundary. If no pair is waiting when a frame starts, that frame carries zeros and a sticky `underrun` flag is raised.

The control state machine has four states. `ST_IDLE` means clocks are stopped and everything is cleared. In `ST_CLKRUN` the clocks run and the data line stays silent. In `ST_ARMED` a transmit enable has been received and the block waits for the next frame boundary. In `ST_TX` it is transmitting. The transitions are:
- IDLE→CLKRUN on clock enable.
- IDLE→ARMED on clock enable and transmit enable in the same cycle.
- CLKRUN→ARMED on transmit enable.
- ARMED→TX at the end of a frame.
- Any state→IDLE on software reset, which takes priority over every other command.

Top module: `i2s_master_tx`

## Requirements
- R1: After `rst_n` is released, and in the cycle after a `cmd_swrst` pulse, these outputs are all 0 until the next clock enable: `mclk`, `bclk`, `ws`, `sdata`, `s_ready`, `tx_active`, `underrun`.
- R2: A one-cycle `cmd_clk_en` pulse starts the clocks. Counting k input clock edges after the edge that takes the pulse, `mclk` is high when k mod 4 ≥ 2 and `bclk` is high when k mod 16 ≥ 8. A `cmd_tx_en` pulse on its own while idle is ignored, and the clocks stay stopped.
- R3: A frame lasts 64 bit clocks. `ws` is 0 (left channel) for bit periods 0–31 and 1 (right channel) for bit periods 32–63, so it is high when k mod 1024 ≥ 512. `ws` changes only where `bclk` falls.
- R4: `sdata` changes only where `bclk` falls. The MSB of a slot is sent in the bit period after the `ws` transition that starts that slot, and it is meant to be sampled on the rising edge of `bclk`.
- R5: A slot is 32 bits sent MSB first: the 16-bit sample, then 16 zero bits. `s_left` goes in the `ws`=0 slot and `s_right` in the `ws`=1 slot.
- R6: `sdata` is 0 whenever `tx_active` is 0.
- R7: After `cmd_tx_en`, `tx_active` rises in the same cycle that `ws` falls at the next frame boundary. For a combined enable, that is exactly 1024 cycles after the command edge. The first frame sent is therefore complete.
- R8: A pair is taken when `s_valid` and `s_ready` are both 1 at a clock edge. `s_ready` is 1 only in the armed or transmitting state while the one-pair buffer is empty. A pair taken during frame N is sent in frame N+1, and pairs are sent in the order they were taken.
- R9: If no pair is waiting at a frame boundary, that frame sends zeros and `underrun` goes to 1. `underrun` stays at 1 until software reset.
- R10: If a pair is taken in the same cycle as a frame boundary while the buffer is empty, that pair goes straight into the new frame, `underrun` is not set, and `s_ready` stays 1.
- R11: When `cmd_swrst` arrives in the same cycle as `cmd_clk_en` or `cmd_tx_en`, the reset wins and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock (master clock ×4, bit clock ×16) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_swrst | input | 1 | One-cycle software reset command |
| cmd_clk_en | input | 1 | One-cycle command to start the clocks |
| cmd_tx_en | input | 1 | One-cycle command to arm the transmitter |
| s_valid | input | 1 | Stream: a sample pair is offered |
| s_ready | output | 1 | Stream: the block can take a pair |
| s_left | input | 16 | Stream: left-channel sample |
| s_right | input | 16 | Stream: right-channel sample |
| mclk | output | 1 | Master clock to the codec |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word select (0 = left, 1 = right) |
| sdata | output | 1 | Serial audio data |
| tx_active | output | 1 | Status: transmission is running |
| underrun | output | 1 | Sticky flag: a frame started with no pair waiting |

## Verification
The interesting collision is a stream handshake that falls in the same cycle as a frame boundary while the buffer is empty. The block has to load the new pair into the frame that is just starting, instead of declaring an underrun or parking the pair for a later frame. The bench provokes this with a combined enable followed by 1023 silent cycles, then offers a pair only in the final cycle before the boundary. It judges the result from three things:
- `underrun` stays 0 and `s_ready` stays 1 just after the edge.
- `tx_active` rises together with the fall of `ws`.
- The first decoded left and right words carry that pair.

A second coincidence is software reset arriving together with an enable command. The bench checks this by watching that the clocks stay stopped.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CLKRUN = 2'd1,
        ST_ARMED  = 2'd2,
        ST_TX     = 2'd3
    } tx_state_e;

endpackage

// File: rtl/i2s_tx_ctrl.sv
module i2s_tx_ctrl
    import i2s_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_swrst,
    input  logic cmd_clk_en,
    input  logic cmd_tx_en,
    input  logic frame_end,
    output logic run,
    output logic accept_en,
    output logic tx_on
);

    tx_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions; software reset outranks every other command
    always_comb begin
        state_d = state_q;
        if (cmd_swrst) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_clk_en && cmd_tx_en) state_d = ST_ARMED;
                    else if (cmd_clk_en)         state_d = ST_CLKRUN;
                end
                ST_CLKRUN: begin
                    if (cmd_tx_en) state_d = ST_ARMED;
                end
                ST_ARMED: begin
                    if (frame_end) state_d = ST_TX;
                end
                ST_TX: begin
                    state_d = ST_TX;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // decoded outputs
    always_comb begin
        run       = 1'b0;
        accept_en = 1'b0;
        tx_on     = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_CLKRUN: run = 1'b1;
            ST_ARMED: begin
                run       = 1'b1;
                accept_en = 1'b1;
            end
            ST_TX: begin
                run       = 1'b1;
                accept_en = 1'b1;
                tx_on     = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/i2s_tx_clkgen.sv
module i2s_tx_clkgen #(
    parameter int MCLK_DIV   = 4,
    parameter int BCLK_DIV   = 16,
    parameter int FRAME_BITS = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    output logic                          mclk,
    output logic                          bclk,
    output logic [$clog2(FRAME_BITS)-1:0] bit_idx,
    output logic                          frame_end
);

    localparam int CW = $clog2(BCLK_DIV);
    localparam int MW = $clog2(MCLK_DIV);
    localparam int IW = $clog2(FRAME_BITS);
    localparam logic [CW-1:0] CNT_LAST = CW'(BCLK_DIV - 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(FRAME_BITS - 1);

    logic [CW-1:0] cnt_q;
    logic [IW-1:0] idx_q;
    logic          wrap;

    assign wrap = (cnt_q == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
            idx_q <= '0;
        end else begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            if (wrap) begin
                idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
            end
        end
    end

    // both clocks are the top bit of a power-of-two count: 50% duty
    assign mclk      = cnt_q[MW-1];
    assign bclk      = cnt_q[CW-1];
    assign bit_idx   = idx_q;
    assign frame_end = wrap && (idx_q == IDX_LAST);

endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer #(
    parameter int SAMPLE_W = 16,
    parameter int SLOT_W   = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          accept_en,
    input  logic                          tx_on,
    input  logic                          frame_end,
    input  logic [$clog2(2*SLOT_W)-1:0]   bit_idx,
    input  logic                          s_valid,
    input  logic [SAMPLE_W-1:0]           s_left,
    input  logic [SAMPLE_W-1:0]           s_right,
    output logic                          s_ready,
    output logic                          ws,
    output logic                          sdata,
    output logic                          underrun
);

    localparam int IW  = $clog2(2 * SLOT_W);
    localparam int PW  = $clog2(SLOT_W);
    localparam int SIW = $clog2(SAMPLE_W);

    logic [SAMPLE_W-1:0] hold_l_q, hold_r_q;
    logic                hold_full_q;
    logic [SAMPLE_W-1:0] act_l_q, act_r_q;
    logic                under_q;
    logic                take;

    assign s_ready = accept_en && !hold_full_q;
    assign take    = s_valid && s_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_l_q    <= '0;
            hold_r_q    <= '0;
            hold_full_q <= 1'b0;
            act_l_q     <= '0;
            act_r_q     <= '0;
            under_q     <= 1'b0;
        end else if (clr) begin
            hold_l_q    <= '0;
            hold_r_q    <= '0;
            hold_full_q <= 1'b0;
            act_l_q     <= '0;
            act_r_q     <= '0;
            under_q     <= 1'b0;
        end else if (frame_end && accept_en) begin
            if (hold_full_q) begin
                act_l_q     <= hold_l_q;
                act_r_q     <= hold_r_q;
                hold_full_q <= 1'b0;
            end else if (take) begin
                // pair arriving in the boundary cycle goes straight out
                act_l_q <= s_left;
                act_r_q <= s_right;
            end else begin
                act_l_q <= '0;
                act_r_q <= '0;
                under_q <= 1'b1;
            end
        end else if (take) begin
            hold_l_q    <= s_left;
            hold_r_q    <= s_right;
            hold_full_q <= 1'b1;
        end
    end

    // slot position 0 carries the previous slot's last (padding) bit;
    // positions 1..SAMPLE_W carry the sample MSB first
    logic                chan;
    logic [PW-1:0]       pos;
    logic [SAMPLE_W-1:0] word;
    logic [SIW-1:0]      bsel;

    always_comb begin
        chan  = bit_idx[IW-1];
        pos   = bit_idx[PW-1:0];
        word  = chan ? act_r_q : act_l_q;
        bsel  = SIW'(SAMPLE_W - int'(pos));
        sdata = tx_on && (pos != '0) && (int'(pos) <= SAMPLE_W) && word[bsel];
    end

    assign ws       = bit_idx[IW-1];
    assign underrun = under_q;

endmodule

// File: rtl/i2s_master_tx.sv
module i2s_master_tx #(
    parameter int MCLK_DIV = 4,
    parameter int BCLK_DIV = 16,
    parameter int SLOT_W   = 32,
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_swrst,
    input  logic                cmd_clk_en,
    input  logic                cmd_tx_en,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic [SAMPLE_W-1:0] s_left,
    input  logic [SAMPLE_W-1:0] s_right,
    output logic                mclk,
    output logic                bclk,
    output logic                ws,
    output logic                sdata,
    output logic                tx_active,
    output logic                underrun
);

    localparam int FRAME_BITS = 2 * SLOT_W;
    localparam int IW         = $clog2(FRAME_BITS);

    logic          run;
    logic          accept_en;
    logic          tx_on;
    logic          frame_end;
    logic          clr;
    logic [IW-1:0] bit_idx;

    assign clr = cmd_swrst || !run;

    i2s_tx_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_swrst  (cmd_swrst),
        .cmd_clk_en (cmd_clk_en),
        .cmd_tx_en  (cmd_tx_en),
        .frame_end  (frame_end),
        .run        (run),
        .accept_en  (accept_en),
        .tx_on      (tx_on)
    );

    i2s_tx_clkgen #(
        .MCLK_DIV   (MCLK_DIV),
        .BCLK_DIV   (BCLK_DIV),
        .FRAME_BITS (FRAME_BITS)
    ) u_clkgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .mclk       (mclk),
        .bclk       (bclk),
        .bit_idx    (bit_idx),
        .frame_end  (frame_end)
    );

    i2s_tx_serializer #(
        .SAMPLE_W   (SAMPLE_W),
        .SLOT_W     (SLOT_W)
    ) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .accept_en  (accept_en),
        .tx_on      (tx_on),
        .frame_end  (frame_end),
        .bit_idx    (bit_idx),
        .s_valid    (s_valid),
        .s_left     (s_left),
        .s_right    (s_right),
        .s_ready    (s_ready),
        .ws         (ws),
        .sdata      (sdata),
        .underrun   (underrun)
    );

    assign tx_active = tx_on;

endmodule

// File: rtl/i2s_master_tx_chk.sv
module i2s_master_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_swrst,
    input logic run,
    input logic mclk,
    input logic bclk,
    input logic ws,
    input logic sdata,
    input logic s_valid,
    input logic s_ready,
    input logic tx_active,
    input logic underrun
);

    // R1: stopped block keeps every output quiet
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!mclk && !bclk && !ws && !sdata && !s_ready && !tx_active && !underrun));

    // R2: no clock toggles on two consecutive cycles while running
    a_r2_mclk_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mclk) && run) |=> ($stable(mclk) || !run));

    a_r2_bclk_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(bclk) && run) |=> ($stable(bclk) || !run));

    // R3: word select moves only with a falling bit clock
    a_r3_ws_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ws) |-> ($fell(bclk) || !run));

    // R4: data moves only with a falling bit clock
    a_r4_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sdata) && run) |-> $fell(bclk));

    // R6: silent line while not transmitting
    a_r6_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> !sdata);

    // R7: status rises exactly at a frame boundary
    a_r7_status_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_active) |-> $fell(ws));

    // R8: ready is not withdrawn without a handshake or reset
    a_r8_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ready && !s_valid && !cmd_swrst) |=> s_ready);

    // R9: underrun can only appear while transmitting
    a_r9_underrun_in_tx: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> tx_active);

endmodule

bind i2s_master_tx i2s_master_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_swrst (cmd_swrst),
    .run       (run),
    .mclk      (mclk),
    .bclk      (bclk),
    .ws        (ws),
    .sdata     (sdata),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .tx_active (tx_active),
    .underrun  (underrun)
);

// File: tb/tb_i2s_master_tx.sv
module tb_i2s_master_tx;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 6;

    // {left in, right in, expected left slot, expected right slot}
    localparam logic [95:0] VEC [NVEC] = '{
        {16'h8000, 16'h0001, 32'h8000_0000, 32'h0001_0000},
        {16'hFFFF, 16'h0000, 32'hFFFF_0000, 32'h0000_0000},
        {16'hA5C3, 16'h5A3C, 32'hA5C3_0000, 32'h5A3C_0000},
        {16'h0001, 16'h8000, 32'h0001_0000, 32'h8000_0000},
        {16'h1234, 16'hFEDC, 32'h1234_0000, 32'hFEDC_0000},
        {16'h7FFF, 16'hC001, 32'h7FFF_0000, 32'hC001_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_swrst = 1'b0;
    logic        cmd_clk_en = 1'b0;
    logic        cmd_tx_en = 1'b0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [15:0] s_left = '0;
    logic [15:0] s_right = '0;
    logic        mclk, bclk, ws, sdata, tx_active, underrun;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2s_master_tx dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_swrst  (cmd_swrst),
        .cmd_clk_en (cmd_clk_en),
        .cmd_tx_en  (cmd_tx_en),
        .s_valid    (s_valid),
        .s_ready    (s_ready),
        .s_left     (s_left),
        .s_right    (s_right),
        .mclk       (mclk),
        .bclk       (bclk),
        .ws         (ws),
        .sdata      (sdata),
        .tx_active  (tx_active),
        .underrun   (underrun)
    );

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // receiver model: samples sdata on bclk rise, I2S one-bit delay
    logic        mon_clr = 1'b0;
    logic        m_prev_bclk = 1'b0;
    logic        m_last_ws = 1'b0;
    logic        m_started = 1'b0;
    logic [31:0] m_word = '0;
    int          m_nb = 0;
    int          rx_n = 0;
    int          idle_bad = 0;
    logic [31:0] rx_w [32];

    always @(negedge clk) begin
        if (mon_clr) begin
            m_prev_bclk <= 1'b0;
            m_last_ws   <= 1'b0;
            m_started   <= 1'b0;
            m_word      <= '0;
            m_nb        <= 0;
            rx_n        <= 0;
        end else begin
            if (!tx_active && sdata) idle_bad <= idle_bad + 1;
            m_prev_bclk <= bclk;
            if (!m_prev_bclk && bclk) begin
                if (ws != m_last_ws) begin
                    if (m_nb == 31 && (m_started || (m_last_ws == 1'b0 && tx_active))) begin
                        m_started <= 1'b1;
                        if (rx_n < 32) rx_w[rx_n] <= {m_word[30:0], sdata};
                        rx_n <= rx_n + 1;
                    end
                    m_word    <= '0;
                    m_nb      <= 0;
                    m_last_ws <= ws;
                end else begin
                    m_word <= {m_word[30:0], sdata};
                    m_nb   <= m_nb + 1;
                end
            end
        end
    end

    task automatic pulse(input logic sw, input logic ce, input logic te);
        cmd_swrst  = sw;
        cmd_clk_en = ce;
        cmd_tx_en  = te;
        @(negedge clk);
        cmd_swrst  = 1'b0;
        cmd_clk_en = 1'b0;
        cmd_tx_en  = 1'b0;
    endtask

    task automatic clear_mon();
        mon_clr = 1'b1;
        repeat (2) @(negedge clk);
        mon_clr = 1'b0;
    endtask

    task automatic chk_quiet(input string req);
        chk(req, {25'd0, mclk, bclk, ws, sdata, s_ready, tx_active, underrun}, 32'd0);
    endtask

    logic wd_hit = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        wd_hit = 1'b1;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk + 1, n_fail + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_quiet("R1 reset state");

        // R2: transmit enable alone while idle is ignored
        pulse(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (i % 10 == 0) chk_quiet("R2 tx_en alone ignored");
        end

        // ---- session A: combined enable, boundary-cycle handshake (R10)
        clear_mon();
        pulse(1'b0, 1'b1, 1'b1);
        for (int k = 0; k < 1024; k++) begin
            if (k > 0) @(negedge clk);
            chk("R2 mclk ratio", {31'd0, mclk}, {31'd0, (k % 4) >= 2});
            chk("R2 bclk ratio", {31'd0, bclk}, {31'd0, (k % 16) >= 8});
            chk("R3 ws frame", {31'd0, ws}, {31'd0, k >= 512});
            chk("R7 status waits", {31'd0, tx_active}, 32'd0);
        end
        chk("R8 ready when armed", {31'd0, s_ready}, 32'd1);
        s_valid = 1'b1;
        s_left  = 16'hC3A5;
        s_right = 16'h0F0F;
        @(negedge clk);
        s_valid = 1'b0;
        chk("R7 status at boundary", {31'd0, tx_active}, 32'd1);
        chk("R3 ws low at frame start", {31'd0, ws}, 32'd0);
        chk("R10 no underrun", {31'd0, underrun}, 32'd0);
        chk("R10 buffer still empty", {31'd0, s_ready}, 32'd1);
        wait (rx_n >= 4);
        @(negedge clk);
        chk("R10 left word", rx_w[0], 32'hC3A5_0000);
        chk("R10 right word", rx_w[1], 32'h0F0F_0000);
        chk("R9 zero left on underrun", rx_w[2], 32'h0);
        chk("R9 zero right on underrun", rx_w[3], 32'h0);
        chk("R9 underrun sticky", {31'd0, underrun}, 32'd1);

        // software reset mid-transmission
        pulse(1'b1, 1'b0, 1'b0);
        chk_quiet("R1 after software reset");

        // ---- session B: vector table through the stream
        clear_mon();
        pulse(1'b0, 1'b1, 1'b0);
        repeat (200) @(negedge clk);
        chk("R2 clocks without status", {30'd0, tx_active, sdata}, 32'd0);
        pulse(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < NVEC; i++) begin
            s_valid = 1'b1;
            s_left  = VEC[i][95:80];
            s_right = VEC[i][79:64];
            while (!s_ready) @(negedge clk);
            @(negedge clk);
        end
        s_valid = 1'b0;
        chk("R9 no early underrun", {31'd0, underrun}, 32'd0);
        wait (rx_n >= 16);
        @(negedge clk);
        for (int i = 0; i < NVEC; i++) begin
            chk("R5 R8 left slot", rx_w[2*i], VEC[i][63:32]);
            chk("R5 R8 right slot", rx_w[2*i+1], VEC[i][31:0]);
        end
        for (int i = 2 * NVEC; i < 16; i++) chk("R9 zero frame", rx_w[i], 32'h0);
        chk("R9 underrun raised", {31'd0, underrun}, 32'd1);
        chk("R4 R6 data silent outside tx", idle_bad, 0);

        // R11: reset wins over a simultaneous enable
        pulse(1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (i % 10 == 0) chk_quiet("R11 reset priority");
        end

        if (!wd_hit) begin
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule